// File: doc/BRIEF.md
# Nonvolatile Memory Write Guard

This block owns the control byte of a small serial nonvolatile memory and decides whether each kind of write may go ahead. The byte holds a pin-guard enable, a two-bit protected-zone code, the write-enable latch and a mirror of the busy flag. The command decoder around it raises single-cycle event pulses for these actions: set latch, clear latch, control byte captured (arm), control-byte write committed, and array write committed. It also supplies the target array address, the busy flag and the level of an active-low guard pin.

Two permission flags come out, and both are combinational from the current state and inputs. The array flag is high when the address lies outside the protected zone and the latch is set. The control flag is high when the latch is set and the guard pin is not locking the byte. A control-byte write is held as pending from the moment its data byte is captured until the commit pulse. While it is pending, a guard pin pulled low while the guard is enabled cancels it. After the commit has been applied, the guard pin cannot undo it.

Top module: `nvm_write_guard`

## Requirements
- R1: `status_o` packs the guard enable in bit 7, zeros in bits 6 to 4, the zone code in bits 3:2, the write latch in bit 1 and the current level of `busy_i` in bit 0.
- R2: While `rst` is high at a clock edge, the latch, guard enable, zone code and any pending control write are all cleared.
- R3: When not busy, `set_latch_i` sets the latch and `clr_latch_i` clears it. If both arrive in the same cycle, the clear wins.
- R4: `arr_wr_ok_o` is 1 exactly when the latch is 1 and `addr_i` lies outside the protected zone.
- R5: For a 2^ADDR_W byte array, zone code 00 protects nothing. Code 01 protects the top quarter (0x300 to 0x3FF at ADDR_W=10), code 10 the top half (0x200 to 0x3FF) and code 11 the whole array.
- R6: `sr_wr_ok_o` is 1 exactly when the latch is 1 and not both guard enable = 1 and `guard_n` = 0.
- R7: When not busy, `sr_arm_i` captures `sr_data_i` as a pending write, but only if the guard is not locking. A later `sr_commit_i` copies bit 7 into the guard enable and bits 3:2 into the zone code, and does so only if the write is still pending, the latch is 1 and the guard is not locking in that cycle. In every other case the byte is left unchanged.
- R8: A pending control write is cancelled in any cycle where the guard enable is 1 and `guard_n` is 0. A later commit then changes nothing, even if `guard_n` has returned high by then.
- R9: Once a commit has been applied, later levels of `guard_n` leave the guard enable and zone code unchanged.
- R10: When not busy, `arr_commit_i` or `sr_commit_i` clears the latch, even if the array write was dropped because the address was protected. This clear takes priority over a set pulse in the same cycle.
- R11: While `busy_i` is 1, set, clear, arm and both commit pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| guard_n | input | 1 | Active-low guard pin level |
| busy_i | input | 1 | Internal write cycle in progress |
| set_latch_i | input | 1 | Set-latch command event |
| clr_latch_i | input | 1 | Clear-latch command event |
| sr_arm_i | input | 1 | Control data byte captured |
| sr_data_i | input | 8 | Control data byte |
| sr_commit_i | input | 1 | Control write committed (select released) |
| arr_commit_i | input | 1 | Array write committed (select released) |
| addr_i | input | ADDR_W | Target array address |
| status_o | output | 8 | Packed control byte |
| arr_wr_ok_o | output | 1 | Array write permitted at `addr_i` |
| sr_wr_ok_o | output | 1 | Control-byte write permitted |

## Verification
Two events can land in the same cycle: the guard pin falling and the commit of a pending control write. Likewise, a set pulse can coincide with a commit that clears the latch. The bench forces both collisions in directed steps. It also drives a long pseudo-random stream in which guard, arm, commit and latch pulses overlap freely. A behavioural model, written from the requirements, predicts the byte and both flags, and every cycle is judged against it. The directed steps check that a commit arriving together with a falling guard is refused, and that the set pulse loses to the clear.

// File: rtl/nvm_guard_pkg.sv
package nvm_guard_pkg;

    typedef enum logic [1:0] {
        ZONE_NONE    = 2'b00,
        ZONE_QUARTER = 2'b01,
        ZONE_HALF    = 2'b10,
        ZONE_ALL     = 2'b11
    } zone_e;

    typedef struct packed {
        logic  guard_en;
        zone_e zone;
        logic  latch;
        logic  busy;
    } ctl_state_t;

    localparam int GUARD_BIT = 7;
    localparam int ZONE_HI   = 3;
    localparam int ZONE_LO   = 2;

    function automatic logic [7:0] pack_ctl(ctl_state_t s);
        return {s.guard_en, 3'b000, s.zone, s.latch, s.busy};
    endfunction

    function automatic zone_e zone_from_byte(logic [7:0] b);
        return zone_e'(b[ZONE_HI:ZONE_LO]);
    endfunction

endpackage

// File: rtl/nvm_zone_decode.sv
module nvm_zone_decode
    import nvm_guard_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  zone_e              zone,
    input  logic [ADDR_W-1:0]  addr,
    output logic               hit
);
    localparam int TOP = ADDR_W - 1;

    always_comb begin
        unique case (zone)
            ZONE_NONE:    hit = 1'b0;
            ZONE_QUARTER: hit = &addr[TOP -: 2];
            ZONE_HALF:    hit = addr[TOP];
            default:      hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/nvm_latch_ctl.sv
module nvm_latch_ctl (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic set_i,
    input  logic clr_i,
    input  logic commit_i,
    output logic latch_o
);
    logic drop;
    assign drop = clr_i | commit_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_o <= 1'b0;
        end else if (!busy) begin
            if (drop)       latch_o <= 1'b0;
            else if (set_i) latch_o <= 1'b1;
        end
    end

    AST_LATCH_SET: assert property (@(posedge clk) disable iff (rst)
        (!busy && set_i && !clr_i && !commit_i) |=> latch_o); // R3
    AST_LATCH_DROP: assert property (@(posedge clk) disable iff (rst)
        (!busy && (clr_i || commit_i)) |=> !latch_o); // R10
    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(latch_o)); // R11
endmodule

// File: rtl/nvm_ctl_fields.sv
module nvm_ctl_fields
    import nvm_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       busy,
    input  logic       guard_n,
    input  logic       latch_i,
    input  logic       arm_i,
    input  logic [7:0] data_i,
    input  logic       commit_i,
    output logic       guard_en_o,
    output zone_e      zone_o,
    output logic       pending_o
);
    logic [7:0] held;
    logic       locked;
    logic       apply;

    assign locked = guard_en_o & ~guard_n;
    assign apply  = !busy && commit_i && pending_o && latch_i && !locked;

    always_ff @(posedge clk) begin
        if (rst) begin
            guard_en_o <= 1'b0;
            zone_o     <= ZONE_NONE;
            pending_o  <= 1'b0;
            held       <= '0;
        end else if (!busy && commit_i) begin
            if (apply) begin
                guard_en_o <= held[GUARD_BIT];
                zone_o     <= zone_from_byte(held);
            end
            pending_o <= 1'b0;
        end else if (!busy && arm_i && !locked) begin
            pending_o <= 1'b1;
            held      <= data_i;
        end else if (locked) begin
            pending_o <= 1'b0;
        end
    end

    AST_LOCK_CANCELS: assert property (@(posedge clk) disable iff (rst)
        (pending_o && guard_en_o && !guard_n) |=> !pending_o); // R8
    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(commit_i && !busy) |=> ($stable(guard_en_o) && $stable(zone_o))); // R9
    AST_NO_BLIND_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (commit_i && !pending_o) |=> ($stable(guard_en_o) && $stable(zone_o))); // R7
endmodule

// File: rtl/nvm_write_guard.sv
module nvm_write_guard
    import nvm_guard_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              guard_n,
    input  logic              busy_i,
    input  logic              set_latch_i,
    input  logic              clr_latch_i,
    input  logic              sr_arm_i,
    input  logic [7:0]        sr_data_i,
    input  logic              sr_commit_i,
    input  logic              arr_commit_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [7:0]        status_o,
    output logic              arr_wr_ok_o,
    output logic              sr_wr_ok_o
);
    logic       latch;
    logic       guard_en;
    zone_e      zone;
    logic       pending;
    logic       in_zone;
    ctl_state_t st;

    nvm_latch_ctl u_latch (
        .clk      (clk),
        .rst      (rst),
        .busy     (busy_i),
        .set_i    (set_latch_i),
        .clr_i    (clr_latch_i),
        .commit_i (sr_commit_i | arr_commit_i),
        .latch_o  (latch)
    );

    nvm_ctl_fields u_fields (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy_i),
        .guard_n    (guard_n),
        .latch_i    (latch),
        .arm_i      (sr_arm_i),
        .data_i     (sr_data_i),
        .commit_i   (sr_commit_i),
        .guard_en_o (guard_en),
        .zone_o     (zone),
        .pending_o  (pending)
    );

    nvm_zone_decode #(.ADDR_W(ADDR_W)) u_zone (
        .zone (zone),
        .addr (addr_i),
        .hit  (in_zone)
    );

    always_comb begin
        st.guard_en = guard_en;
        st.zone     = zone;
        st.latch    = latch;
        st.busy     = busy_i;
    end

    assign status_o    = pack_ctl(st);
    assign arr_wr_ok_o = latch & ~in_zone;
    assign sr_wr_ok_o  = latch & ~(guard_en & ~guard_n);

    AST_FULL_ZONE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (zone == ZONE_ALL) |-> !arr_wr_ok_o); // R5
    AST_NO_LATCH_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !status_o[1] |-> (!arr_wr_ok_o && !sr_wr_ok_o)); // R4
    AST_COMMIT_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (rst)
        (sr_commit_i && !sr_wr_ok_o) |=> ($stable(status_o[7]) && $stable(status_o[3:2]))); // R6
endmodule

// File: tb/nvm_write_guard_test.sv
`timescale 1ns/1ps
module nvm_write_guard_test;
    localparam int AW = 10;
    localparam int WATCHDOG_NS = 400000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic guard_n = 1'b1, busy_i = 1'b0;
    logic set_latch_i = 1'b0, clr_latch_i = 1'b0, sr_arm_i = 1'b0;
    logic sr_commit_i = 1'b0, arr_commit_i = 1'b0;
    logic [7:0] sr_data_i = 8'h00;
    logic [AW-1:0] addr_i = '0;
    logic [7:0] status_o;
    logic arr_wr_ok_o, sr_wr_ok_o;

    nvm_write_guard #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .guard_n(guard_n), .busy_i(busy_i),
        .set_latch_i(set_latch_i), .clr_latch_i(clr_latch_i),
        .sr_arm_i(sr_arm_i), .sr_data_i(sr_data_i), .sr_commit_i(sr_commit_i),
        .arr_commit_i(arr_commit_i), .addr_i(addr_i),
        .status_o(status_o), .arr_wr_ok_o(arr_wr_ok_o), .sr_wr_ok_o(sr_wr_ok_o)
    );

    always #2 clk = ~clk;

    int compared = 0, mismatched = 0;
    bit started = 0, finished = 0;

    // reference model state
    int m_latch = 0, m_gen = 0, m_zone = 0, m_pend = 0, m_held = 0;

    function automatic int protected_addr(int a, int z);
        int size = 1 << AW;
        case (z)
            1: return (a >= size - size / 4) ? 1 : 0;
            2: return (a >= size / 2) ? 1 : 0;
            3: return 1;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        int lock, nl;
        started <= 1'b1;
        lock = (m_gen == 1 && guard_n == 1'b0) ? 1 : 0;
        if (rst) begin
            m_latch = 0; m_gen = 0; m_zone = 0; m_pend = 0;   // R2
        end else begin
            nl = m_latch;
            if (!busy_i) begin                                // R11
                if (clr_latch_i || sr_commit_i || arr_commit_i) nl = 0;   // R3 R10
                else if (set_latch_i) nl = 1;
            end
            if (!busy_i && sr_commit_i) begin                 // R7
                if (m_pend == 1 && m_latch == 1 && lock == 0) begin
                    m_gen  = (m_held >> 7) & 1;
                    m_zone = (m_held >> 2) & 3;
                end
                m_pend = 0;
            end else if (!busy_i && sr_arm_i && lock == 0) begin
                m_pend = 1; m_held = int'(sr_data_i);
            end else if (lock == 1) begin
                m_pend = 0;                                   // R8
            end
            m_latch = nl;
        end
    end

    always @(negedge clk) begin
        int exp_st, exp_arr, exp_sr;
        if (started && !finished) begin
            exp_st  = (m_gen << 7) | (m_zone << 2) | (m_latch << 1) | (busy_i ? 1 : 0);
            exp_arr = (m_latch == 1 && protected_addr(int'(addr_i), m_zone) == 0) ? 1 : 0;
            exp_sr  = (m_latch == 1 && !(m_gen == 1 && guard_n == 1'b0)) ? 1 : 0;
            compared += 3;
            if (int'(status_o) != exp_st) begin
                mismatched++;
                $display("FAIL R1/R2/R3/R7/R8/R9/R10/R11 status_o got %02h expected %02h at %0t", status_o, exp_st[7:0], $time);
            end
            if (int'(arr_wr_ok_o) != exp_arr) begin
                mismatched++;
                $display("FAIL R4/R5 arr_wr_ok_o got %0d expected %0d addr %03h at %0t", arr_wr_ok_o, exp_arr, addr_i, $time);
            end
            if (int'(sr_wr_ok_o) != exp_sr) begin
                mismatched++;
                $display("FAIL R6 sr_wr_ok_o got %0d expected %0d at %0t", sr_wr_ok_o, exp_sr, $time);
            end
        end
    end

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic idle_pulses();
        set_latch_i = 0; clr_latch_i = 0; sr_arm_i = 0; sr_commit_i = 0; arr_commit_i = 0;
    endtask

    task automatic status_write(logic [7:0] d);
        sr_data_i = d; sr_arm_i = 1; tick(); idle_pulses(); tick();
        sr_commit_i = 1; tick(); idle_pulses(); tick();
    endtask

    task automatic sweep_addr();
        for (int a = 0; a < (1 << AW); a += 64) begin
            addr_i = AW'(a); tick();
        end
        addr_i = '1; tick();
    endtask

    initial begin
        tick(3);                       // R2 reset state compared each cycle
        rst = 0; tick(2);
        // R3: set, clear, clear wins over set
        set_latch_i = 1; tick(); idle_pulses(); tick();
        clr_latch_i = 1; tick(); idle_pulses(); tick();
        set_latch_i = 1; tick(); idle_pulses();
        set_latch_i = 1; clr_latch_i = 1; tick(); idle_pulses(); tick();
        // R5 R4: each zone code, address sweep
        for (int z = 0; z < 4; z++) begin
            set_latch_i = 1; tick(); idle_pulses();
            status_write(8'(z << 2));
            set_latch_i = 1; tick(); idle_pulses();
            sweep_addr();
            // R10: dropped write into protected zone still clears latch; set loses
            addr_i = '1; arr_commit_i = 1; set_latch_i = 1; tick(); idle_pulses(); tick();
        end
        // R7: only bits 7,3,2 take effect
        set_latch_i = 1; tick(); idle_pulses();
        status_write(8'h7B);
        // R6 R8: guard enabled, pin low cancels pending write
        set_latch_i = 1; tick(); idle_pulses();
        status_write(8'h80);
        set_latch_i = 1; tick(); idle_pulses();
        sr_data_i = 8'h0C; sr_arm_i = 1; tick(); idle_pulses();
        guard_n = 0; tick(); guard_n = 1; tick();
        sr_commit_i = 1; tick(); idle_pulses(); tick();
        // same cycle: guard falls together with commit
        set_latch_i = 1; tick(); idle_pulses();
        sr_data_i = 8'h08; sr_arm_i = 1; tick(); idle_pulses();
        guard_n = 0; sr_commit_i = 1; tick(); idle_pulses(); guard_n = 1; tick();
        // R9: applied write unaffected by later pin levels
        set_latch_i = 1; tick(); idle_pulses();
        status_write(8'h84);
        guard_n = 0; tick(3); guard_n = 1; tick(2);
        // R11: busy ignores all events
        busy_i = 1;
        set_latch_i = 1; tick(); idle_pulses();
        sr_data_i = 8'h00; sr_arm_i = 1; tick(); idle_pulses();
        sr_commit_i = 1; arr_commit_i = 1; tick(); idle_pulses();
        busy_i = 0; tick(2);
        // mixed pseudo-random phase
        begin
            logic [31:0] lf = 32'h1ACE_B00C;
            for (int i = 0; i < 6000; i++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                rst          = (lf[5:0] == 6'd0);
                busy_i       = (lf[8:6] == 3'd0);
                set_latch_i  = (lf[10:9] == 2'd0);
                clr_latch_i  = (lf[13:11] == 3'd0);
                sr_arm_i     = (lf[15:14] == 2'd0);
                sr_commit_i  = (lf[18:16] == 3'd0);
                arr_commit_i = (lf[22:19] == 4'd0);
                guard_n      = (lf[24:23] != 2'd0);
                sr_data_i    = lf[31:24] ^ lf[7:0];
                addr_i       = lf[AW+11:12];
                tick();
            end
        end
        rst = 0; idle_pulses(); busy_i = 0; guard_n = 1; tick(2);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(WATCHDOG_NS);
        if (!finished) begin
            finished = 1;
            compared++; mismatched++;
            $display("FAIL watchdog expired: got running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule